// File: doc/BRIEF.md
# Function-Group Reset and Power-State Tracker

This block is the control core that decides how an audio function group and its widgets react to reset and power verbs. An upstream decoder hands it one verb per cycle as a target node, a verb kind and a two-bit payload. The block chooses whether to act on the verb or drop it. It keeps a D0/D3 state for the group node and for each widget, and it tells a single function-group reset apart from a back-to-back pair. The pair acts as a deep reset. The block also keeps sticky "settings were reset" flags per widget, plus a separately latched group flag that software reads through the group node.

Node 1 is the function group. Widget `i` is node `i+2`, for `i` from 0 to `N_WIDGET-1`. Every other node number is out of range. A link-reset input puts running widgets into a low-power operating mode. The power state they report does not change. The outputs are an accept/ignore decision in the verb's own cycle and a registered response strobe with data. There are also one-cycle clear pulses toward the stream registers and the general settings registers, and the state bits themselves.

Verb kind encoding: 0 = get power state, 1 = set power state, 2 = function-group reset, 3 = any other set verb, 4 = any other get verb. Codes 5 to 7 are unknown. Set-power payload: 0 selects D0 and 3 selects D3.

Top module: `fgpt_tracker`

## Requirements
- R1: After power-on reset, every widget and the group are in D0 and no widget is in low-power mode. Each widget flag equals its bit in `EPSS_MASK`, the group flag is 1, and `resp_valid`, `stream_clr` and `settings_clr` are 0.
- R2: A verb is ignored if it targets a node outside 1..`N_WIDGET`+1, uses an unknown kind, or is a function-group reset sent to a widget node. An ignored verb raises `verb_ignore` and leaves every output state unchanged.
- R3: `resp_valid` is 1 in the cycle after a verb is accepted and 0 after a cycle with no accepted verb. `verb_accept` and `verb_ignore` are never both 1.
- R4: A get-power-state response carries the targeted node's flag in `resp_data[1]` and its D3 bit in `resp_data[0]`. Both are the values held before that verb. Other responses carry 0.
- R5: A set-power-state verb with payload 0 or 3 moves the target to D0 or D3. Payloads 1 and 2 are ignored and the state is kept.
- R6: A single function-group reset is accepted with a response. It pulses `stream_clr` for one cycle with `CONV_MASK`. It changes no power state and sets no flag.
- R7: A second function-group reset to node 1, with no verb between it and the first, is a deep reset, however many idle cycles separate the two. It pulses `settings_clr` and `stream_clr`. It returns the group and all widgets to D0 and clears low-power mode. It sets each widget flag to its `EPSS_MASK` bit and sets the group flag.
- R8: Any verb other than a function-group reset to node 1, accepted or not, cancels a pending first reset. So does link reset.
- R9: A widget's flag clears when an accepted set verb (power or other) targets it. It also clears once an accepted get-power-state to it has been answered, and that answer still shows 1.
- R10: The group flag clears only on an accepted get-power-state to node 1. Widget flags clearing does not clear it.
- R11: While the group is in D3, the only verbs acted on are get/set power state to node 1 and a reset that completes a deep reset. A first reset in D3 is ignored but still arms the pair.
- R12: During link reset, any verb is ignored. Widgets in D0 enter low-power mode, while D3 bits and all flags are kept. An accepted set-power-state to a widget ends its low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| link_reset | input | 1 | Link reset held high |
| verb_valid | input | 1 | A decoded verb is present this cycle |
| verb_node | input | NODE_W | Target node number |
| verb_kind | input | 3 | Verb kind code |
| verb_payload | input | 2 | Requested power state for set-power verbs |
| verb_accept | output | 1 | Verb is acted on (same cycle) |
| verb_ignore | output | 1 | Verb is dropped (same cycle) |
| resp_valid | output | 1 | Response strobe, one cycle after acceptance |
| resp_data | output | 2 | Response payload {flag, D3} |
| stream_clr | output | N_WIDGET | One-cycle clear of converter stream settings |
| settings_clr | output | 1 | One-cycle clear of general settings (deep reset) |
| widget_d3 | output | N_WIDGET | Reported D3 state per widget |
| widget_lowpwr | output | N_WIDGET | Low-power operating mode per widget |
| widget_psr | output | N_WIDGET | Sticky settings-reset flag per widget |
| group_d3 | output | 1 | Reported D3 state of the group |
| group_psr | output | 1 | Latched group settings-reset flag |

## Verification
The pending-reset bit is the one piece of internal state with no port of its own. If it is wrong, the only sign is the next function-group reset: it shows up as a `settings_clr` pulse that is missing or not expected, one cycle after that verb. A wrong flag or power bit is visible directly at the state outputs after the edge that should have changed it. It also shows in the `resp_data` of the next get-power-state, so the bench reads every flag back through a response as well as through the state pins. Gating faults show in the same cycle as the verb, on `verb_accept`/`verb_ignore`, and one cycle later as a missing or extra `resp_valid`.

// File: rtl/fgpt_pkg.sv
package fgpt_pkg;

    typedef enum logic [2:0] {
        VK_GET_PWR   = 3'd0,
        VK_SET_PWR   = 3'd1,
        VK_FG_RESET  = 3'd2,
        VK_SET_OTHER = 3'd3,
        VK_GET_OTHER = 3'd4
    } verb_kind_e;

    localparam logic [1:0] PS_D0 = 2'd0;
    localparam logic [1:0] PS_D3 = 2'd3;

    typedef struct packed {
        logic d3;
        logic lowpwr;
        logic psr;
    } widget_state_t;

endpackage

// File: rtl/fgpt_gate.sv
module fgpt_gate
    import fgpt_pkg::*;
#(
    parameter int N_WIDGET = 4,
    parameter int NODE_W   = 8
) (
    input  logic                verb_valid,
    input  logic [NODE_W-1:0]   verb_node,
    input  logic [2:0]          verb_kind,
    input  logic [1:0]          verb_payload,
    input  logic                link_reset,
    input  logic                fg_d3,
    input  logic                pending,
    output logic                accept,
    output logic                ignore,
    output logic                fgr_seen,
    output logic                do_single,
    output logic                do_deep,
    output logic                tgt_group,
    output logic [N_WIDGET-1:0] tgt_widget,
    output logic                k_get_pwr,
    output logic                k_set_pwr,
    output logic                k_set_any,
    output logic                new_d3
);
    localparam logic [NODE_W-1:0] GROUP_NODE = NODE_W'(1);
    localparam logic [NODE_W-1:0] LAST_NODE  = NODE_W'(N_WIDGET + 1);

    logic node_ok, is_grp, kind_ok, pay_ok, is_fgr, d0_ok, d3_ok, live;

    always_comb begin
        live      = verb_valid && !link_reset;
        is_grp    = (verb_node == GROUP_NODE);
        node_ok   = (verb_node >= GROUP_NODE) && (verb_node <= LAST_NODE);
        kind_ok   = (verb_kind <= 3'd4);
        k_get_pwr = (verb_kind == VK_GET_PWR);
        k_set_pwr = (verb_kind == VK_SET_PWR);
        k_set_any = k_set_pwr || (verb_kind == VK_SET_OTHER);
        is_fgr    = (verb_kind == VK_FG_RESET);
        new_d3    = (verb_payload == PS_D3);
        pay_ok    = !k_set_pwr || (verb_payload == PS_D0) || (verb_payload == PS_D3);

        fgr_seen  = live && is_fgr && is_grp;
        do_deep   = fgr_seen && pending;

        d0_ok     = node_ok && kind_ok && pay_ok && (!is_fgr || is_grp);
        d3_ok     = ((k_get_pwr || k_set_pwr) && is_grp && pay_ok) || do_deep;

        accept    = live && (fg_d3 ? d3_ok : d0_ok);
        ignore    = verb_valid && !accept;
        do_single = accept && is_fgr && !pending;
        tgt_group = accept && is_grp;
    end

    for (genvar i = 0; i < N_WIDGET; i++) begin : g_tgt
        assign tgt_widget[i] = accept && (verb_node == NODE_W'(i + 2));
    end

endmodule

// File: rtl/fgpt_widget.sv
module fgpt_widget
    import fgpt_pkg::*;
#(
    parameter bit HAS_EPSS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic k_set_pwr,
    input  logic k_set_any,
    input  logic k_get_pwr,
    input  logic new_d3,
    input  logic deep,
    input  logic link_rst,
    output logic d3,
    output logic lowpwr,
    output logic psr
);
    widget_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (deep) begin
            st_d.d3     = 1'b0;
            st_d.lowpwr = 1'b0;
            st_d.psr    = HAS_EPSS;
        end else begin
            if (link_rst && !st_q.d3) begin
                st_d.lowpwr = 1'b1;
            end
            if (sel && k_set_pwr) begin
                st_d.d3     = new_d3;
                st_d.lowpwr = 1'b0;
            end
            if (sel && (k_set_any || k_get_pwr)) begin
                st_d.psr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{d3: 1'b0, lowpwr: 1'b0, psr: HAS_EPSS};
        end else begin
            st_q <= st_d;
        end
    end

    assign d3     = st_q.d3;
    assign lowpwr = st_q.lowpwr;
    assign psr    = st_q.psr;

endmodule

// File: rtl/fgpt_tracker.sv
module fgpt_tracker
    import fgpt_pkg::*;
#(
    parameter int                  N_WIDGET  = 4,
    parameter int                  NODE_W    = 8,
    parameter logic [N_WIDGET-1:0] EPSS_MASK = 4'b0111,
    parameter logic [N_WIDGET-1:0] CONV_MASK = 4'b0011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_reset,
    input  logic                verb_valid,
    input  logic [NODE_W-1:0]   verb_node,
    input  logic [2:0]          verb_kind,
    input  logic [1:0]          verb_payload,
    output logic                verb_accept,
    output logic                verb_ignore,
    output logic                resp_valid,
    output logic [1:0]          resp_data,
    output logic [N_WIDGET-1:0] stream_clr,
    output logic                settings_clr,
    output logic [N_WIDGET-1:0] widget_d3,
    output logic [N_WIDGET-1:0] widget_lowpwr,
    output logic [N_WIDGET-1:0] widget_psr,
    output logic                group_d3,
    output logic                group_psr
);
    localparam logic ANY_EPSS = |EPSS_MASK;

    typedef struct packed {
        logic                fg_d3;
        logic                grp_psr;
        logic                pending;
        logic                resp_v;
        logic [1:0]          resp_d;
        logic [N_WIDGET-1:0] stream_clr;
        logic                settings_clr;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                accept, fgr_seen, do_single, do_deep, tgt_group;
    logic                k_get_pwr, k_set_pwr, k_set_any, new_d3;
    logic [N_WIDGET-1:0] tgt_widget;

    fgpt_gate #(.N_WIDGET(N_WIDGET), .NODE_W(NODE_W)) u_gate (
        .verb_valid   (verb_valid),
        .verb_node    (verb_node),
        .verb_kind    (verb_kind),
        .verb_payload (verb_payload),
        .link_reset   (link_reset),
        .fg_d3        (s_q.fg_d3),
        .pending      (s_q.pending),
        .accept       (accept),
        .ignore       (verb_ignore),
        .fgr_seen     (fgr_seen),
        .do_single    (do_single),
        .do_deep      (do_deep),
        .tgt_group    (tgt_group),
        .tgt_widget   (tgt_widget),
        .k_get_pwr    (k_get_pwr),
        .k_set_pwr    (k_set_pwr),
        .k_set_any    (k_set_any),
        .new_d3       (new_d3)
    );

    for (genvar i = 0; i < N_WIDGET; i++) begin : g_widget
        fgpt_widget #(.HAS_EPSS(EPSS_MASK[i])) u_widget (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (tgt_widget[i]),
            .k_set_pwr (k_set_pwr),
            .k_set_any (k_set_any),
            .k_get_pwr (k_get_pwr),
            .new_d3    (new_d3),
            .deep      (do_deep),
            .link_rst  (link_reset),
            .d3        (widget_d3[i]),
            .lowpwr    (widget_lowpwr[i]),
            .psr       (widget_psr[i])
        );
    end

    always_comb begin
        s_d              = s_q;
        s_d.resp_v       = accept;
        s_d.resp_d       = 2'b00;
        s_d.stream_clr   = '0;
        s_d.settings_clr = 1'b0;

        if (link_reset) begin
            s_d.pending = 1'b0;
        end else if (verb_valid) begin
            s_d.pending = fgr_seen && !s_q.pending;
        end

        if (accept && k_get_pwr) begin
            if (tgt_group) begin
                s_d.resp_d = {s_q.grp_psr, s_q.fg_d3};
            end else begin
                for (int i = 0; i < N_WIDGET; i++) begin
                    if (tgt_widget[i]) begin
                        s_d.resp_d = {widget_psr[i], widget_d3[i]};
                    end
                end
            end
        end

        if (tgt_group && k_set_pwr) begin
            s_d.fg_d3 = new_d3;
        end
        if (tgt_group && k_get_pwr) begin
            s_d.grp_psr = 1'b0;
        end

        if (do_single) begin
            s_d.stream_clr = CONV_MASK;
        end
        if (do_deep) begin
            s_d.stream_clr   = CONV_MASK;
            s_d.settings_clr = 1'b1;
            s_d.fg_d3        = 1'b0;
            s_d.grp_psr      = ANY_EPSS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{fg_d3: 1'b0, grp_psr: ANY_EPSS, pending: 1'b0, resp_v: 1'b0,
                     resp_d: 2'b00, stream_clr: '0, settings_clr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign verb_accept  = accept;
    assign resp_valid   = s_q.resp_v;
    assign resp_data    = s_q.resp_d;
    assign stream_clr   = s_q.stream_clr;
    assign settings_clr = s_q.settings_clr;
    assign group_d3     = s_q.fg_d3;
    assign group_psr    = s_q.grp_psr;

endmodule

// File: rtl/fgpt_checker.sv
module fgpt_checker
    import fgpt_pkg::*;
#(
    parameter int                  N_WIDGET  = 4,
    parameter logic [N_WIDGET-1:0] EPSS_MASK = 4'b0111
) (
    input logic                clk,
    input logic                rst_n,
    input logic                link_reset,
    input logic                verb_valid,
    input logic [2:0]          verb_kind,
    input logic                verb_accept,
    input logic                verb_ignore,
    input logic                resp_valid,
    input logic                settings_clr,
    input logic [N_WIDGET-1:0] widget_d3,
    input logic [N_WIDGET-1:0] widget_psr,
    input logic                group_d3,
    input logic                group_psr
);
    AST_DECISION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(verb_accept && verb_ignore));  // R3

    AST_RESP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        verb_accept |=> resp_valid);  // R3

    AST_NO_RESP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !verb_accept |=> !resp_valid);  // R3

    AST_DEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        settings_clr |-> (widget_d3 == '0) && !group_d3 && group_psr && (widget_psr == EPSS_MASK));  // R7

    AST_FLAG_RISES_ONLY_ON_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(widget_psr & ~$past(widget_psr))) |-> settings_clr);  // R6

    AST_D3_DROPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (verb_valid && group_d3 && (verb_kind == VK_SET_OTHER || verb_kind == VK_GET_OTHER)) |-> verb_ignore);  // R11

    AST_LINK_DROPS_VERB: assert property (@(posedge clk) disable iff (!rst_n)
        (verb_valid && link_reset) |-> verb_ignore);  // R12

    AST_LINK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset |=> (widget_d3 == $past(widget_d3)) && (widget_psr == $past(widget_psr)));  // R12

endmodule

bind fgpt_tracker fgpt_checker #(.N_WIDGET(N_WIDGET), .EPSS_MASK(EPSS_MASK)) u_fgpt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_reset   (link_reset),
    .verb_valid   (verb_valid),
    .verb_kind    (verb_kind),
    .verb_accept  (verb_accept),
    .verb_ignore  (verb_ignore),
    .resp_valid   (resp_valid),
    .settings_clr (settings_clr),
    .widget_d3    (widget_d3),
    .widget_psr   (widget_psr),
    .group_d3     (group_d3),
    .group_psr    (group_psr)
);

// File: tb/fgpt_tracker_test.sv
`timescale 1ns/1ps
module fgpt_tracker_test;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_reset = 1'b0;
    logic          verb_valid = 1'b0;
    logic [7:0]    verb_node = '0;
    logic [2:0]    verb_kind = '0;
    logic [1:0]    verb_payload = '0;
    logic          verb_accept, verb_ignore, resp_valid, settings_clr, group_d3, group_psr;
    logic [1:0]    resp_data;
    logic [NW-1:0] stream_clr, widget_d3, widget_lowpwr, widget_psr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fgpt_tracker #(.N_WIDGET(NW), .NODE_W(8), .EPSS_MASK(4'b0111), .CONV_MASK(4'b0011)) uut (
        .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .verb_valid(verb_valid),
        .verb_node(verb_node), .verb_kind(verb_kind), .verb_payload(verb_payload),
        .verb_accept(verb_accept), .verb_ignore(verb_ignore), .resp_valid(resp_valid),
        .resp_data(resp_data), .stream_clr(stream_clr), .settings_clr(settings_clr),
        .widget_d3(widget_d3), .widget_lowpwr(widget_lowpwr), .widget_psr(widget_psr),
        .group_d3(group_d3), .group_psr(group_psr)
    );

    // Vector: {node[19:12], kind[11:9], payload[8:7], accept[6], resp_data[5:4], req[3:0]}
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {8'd1, 3'd0, 2'd0, 1'b1, 2'b10, 4'd10}, // R10 group flag read
        {8'd1, 3'd0, 2'd0, 1'b1, 2'b00, 4'd10}, // R10 cleared by that read
        {8'd2, 3'd0, 2'd0, 1'b1, 2'b10, 4'd4},  // R4 widget 0 flag
        {8'd2, 3'd0, 2'd0, 1'b1, 2'b00, 4'd9},  // R9 cleared after answer
        {8'd3, 3'd3, 2'd0, 1'b1, 2'b00, 4'd9},  // R9 other set to widget 1
        {8'd3, 3'd0, 2'd0, 1'b1, 2'b00, 4'd9},  // R9 widget 1 flag gone
        {8'd5, 3'd0, 2'd0, 1'b1, 2'b00, 4'd4},  // R4 widget 3 lacks the flag
        {8'd4, 3'd0, 2'd0, 1'b1, 2'b10, 4'd4},  // R4 widget 2 flag
        {8'd0, 3'd0, 2'd0, 1'b0, 2'b00, 4'd2},  // R2 node 0
        {8'd6, 3'd0, 2'd0, 1'b0, 2'b00, 4'd2},  // R2 node past range
        {8'd2, 3'd2, 2'd0, 1'b0, 2'b00, 4'd2},  // R2 reset to a widget
        {8'd2, 3'd5, 2'd0, 1'b0, 2'b00, 4'd2},  // R2 unknown kind
        {8'd2, 3'd1, 2'd3, 1'b1, 2'b00, 4'd5},  // R5 to D3
        {8'd2, 3'd0, 2'd0, 1'b1, 2'b01, 4'd5},  // R5 reads D3
        {8'd2, 3'd1, 2'd1, 1'b0, 2'b00, 4'd5},  // R5 payload 1 dropped
        {8'd2, 3'd0, 2'd0, 1'b1, 2'b01, 4'd5},  // R5 still D3
        {8'd2, 3'd1, 2'd0, 1'b1, 2'b00, 4'd5},  // R5 back to D0
        {8'd2, 3'd0, 2'd0, 1'b1, 2'b00, 4'd5}   // R5 reads D0
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] n, input logic [2:0] k, input logic [1:0] p,
                        input logic lk, output logic acc, output logic ign);
        @(negedge clk);
        verb_valid = 1'b1; verb_node = n; verb_kind = k; verb_payload = p; link_reset = lk;
        #2;
        acc = verb_accept;
        ign = verb_ignore;
        @(negedge clk);
        verb_valid = 1'b0; link_reset = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic a, ig;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 widget_d3", int'(widget_d3), 0);
        chk("R1 widget_lowpwr", int'(widget_lowpwr), 0);
        chk("R1 widget_psr", int'(widget_psr), 'h7);
        chk("R1 group_psr/d3", int'({group_psr, group_d3}), 2);
        chk("R1 pulses/resp", int'({resp_valid, stream_clr, settings_clr}), 0);

        // Table walk: R2 R3 R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][19:12], VEC[v][11:9], VEC[v][8:7], 1'b0, a, ig);
            chk($sformatf("R%0d vec%0d accept", VEC[v][3:0], v), int'({a, ig}), int'({VEC[v][6], ~VEC[v][6]}));
            chk($sformatf("R3 vec%0d resp_valid", v), int'(resp_valid), int'(VEC[v][6]));
            if (VEC[v][6])
                chk($sformatf("R%0d vec%0d resp_data", VEC[v][3:0], v), int'(resp_data), int'(VEC[v][5:4]));
        end
        chk("R2 state untouched by drops", int'(widget_d3), 0);

        // R6 single reset: stream pulse only, no flag set
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R6 accept", int'(a), 1);
        chk("R6 resp_valid", int'(resp_valid), 1);
        chk("R6 stream_clr", int'(stream_clr), 'h3);
        chk("R6 settings_clr", int'(settings_clr), 0);
        chk("R6 widget_psr", int'(widget_psr), 0);
        chk("R6 group_psr", int'(group_psr), 0);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(stream_clr), 0);

        // R8 an intervening verb cancels the pair
        send(8'd2, 3'd4, 2'd0, 1'b0, a, ig);
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R8 still single after other get", int'({settings_clr, stream_clr}), 'h3);
        send(8'd3, 3'd1, 2'd3, 1'b0, a, ig);
        chk("R5 widget1 to D3", int'(widget_d3), 'h2);
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R8 single after set", int'(settings_clr), 0);
        repeat (5) @(negedge clk);
        // R7 deep reset across idle cycles
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R7 settings_clr", int'(settings_clr), 1);
        chk("R7 stream_clr", int'(stream_clr), 'h3);
        chk("R7 widget_d3", int'(widget_d3), 0);
        chk("R7 widget_psr", int'(widget_psr), 'h7);
        chk("R7 group_psr", int'(group_psr), 1);

        // R11 gating in D3
        send(8'd1, 3'd1, 2'd3, 1'b0, a, ig);
        chk("R11 group to D3", int'(group_d3), 1);
        send(8'd2, 3'd3, 2'd0, 1'b0, a, ig);
        chk("R11 other set dropped", int'({a, ig}), 1);
        send(8'd2, 3'd0, 2'd0, 1'b0, a, ig);
        chk("R11 widget get dropped", int'({a, ig, resp_valid}), 'h2);
        chk("R11 widget flag kept", int'(widget_psr), 'h7);
        send(8'd1, 3'd0, 2'd0, 1'b0, a, ig);
        chk("R11 group get accepted", int'(a), 1);
        chk("R4 group response", int'(resp_data), 3);
        chk("R10 group flag cleared", int'(group_psr), 0);
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R11 first reset dropped", int'({a, resp_valid, stream_clr}), 0);
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R11 second reset deep", int'({a, settings_clr, group_d3}), 'h6);

        // R12 link reset
        send(8'd4, 3'd1, 2'd3, 1'b0, a, ig);
        chk("R9 set clears widget2 flag", int'(widget_psr), 'h3);
        send(8'd1, 3'd0, 2'd0, 1'b1, a, ig);
        chk("R12 verb dropped", int'({a, ig, resp_valid}), 'h2);
        chk("R12 lowpwr", int'(widget_lowpwr), 'hB);
        chk("R12 d3 kept", int'(widget_d3), 'h4);
        chk("R12 flags kept", int'({group_psr, widget_psr}), 'h13);
        send(8'd2, 3'd1, 2'd0, 1'b0, a, ig);
        chk("R12 set ends lowpwr", int'(widget_lowpwr), 'hA);

        // R8 link reset cancels a pending reset
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        @(negedge clk); link_reset = 1'b1;
        @(negedge clk); link_reset = 1'b0;
        send(8'd1, 3'd2, 2'd0, 1'b0, a, ig);
        chk("R8 link cancels pair", int'({settings_clr, stream_clr}), 'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule